// File: doc/BRIEF.md
# Private Peripheral Region Decoder with Timer Interrupt Capture

This block sits at the front of the 8 KB private peripheral window of a multiprocessor cluster. It takes a 13-bit offset into that window and picks exactly one target, or flags a decode error. The targets are the snoop-control register bank, the interrupt-controller CPU-interface slots, the timer and watchdog sub-windows, and the interrupt distributor. Alongside the target select it reports a slot or CPU index and the offset local to the chosen target. The decode is purely combinational. The targets themselves live elsewhere.

The CPU-interface slots and the timer/watchdog slots both start with a "current CPU" alias. Slot index 0 is that alias, and slots 1 to `NUM_CPU` are fixed per-CPU views. Each timer/watchdog slot is 0x100 bytes wide. Its timer occupies the first 0x20 bytes and its watchdog the next 0x20 bytes.

The block also watches the level interrupt outputs of every CPU's timer and watchdog. Input `i` is a timer when `i` is even and a watchdog when `i` is odd, and it belongs to CPU `i>>1`. Each input has its own two-state machine. State LOW moves to state HIGH on the transition FIRE, which happens when the input is seen high and raises a one-cycle pending strobe. State HIGH moves back to state LOW on the transition ARM, which happens when the input is seen low and produces no strobe. Each strobe comes with the target CPU and the private interrupt number: 29 for a timer, 30 for a watchdog. Strobes from several inputs are presented side by side in a vector, so none is dropped.

Top module: `privreg_router`

## Requirements
- R1: Offsets 0x000 to 0x0FF select the snoop-control bank: `tgt_sel` = 5'b00001, `tgt_idx` = 0, `tgt_off` = offset[7:0].
- R2: Offsets 0x100 + s*0x100 + b, with s from 0 to NUM_CPU and b from 0x00 to 0xFF, select a CPU-interface slot: `tgt_sel` = 5'b00010, `tgt_idx` = s (0 is the current-CPU alias), `tgt_off` = b.
- R3: Offsets 0x600 + k*0x100 + b, with k from 0 to NUM_CPU and b from 0x00 to 0x1F, select a timer: `tgt_sel` = 5'b00100, `tgt_idx` = k, `tgt_off` = b.
- R4: Offsets 0x620 + k*0x100 + b, with k from 0 to NUM_CPU and b from 0x00 to 0x1F, select a watchdog: `tgt_sel` = 5'b01000, `tgt_idx` = k, `tgt_off` = b.
- R5: Offsets 0x1000 to 0x1FFF select the distributor: `tgt_sel` = 5'b10000, `tgt_idx` = 0, `tgt_off` = offset - 0x1000.
- R6: Any other offset gives `dec_err` = 1 with `tgt_sel`, `tgt_idx` and `tgt_off` all 0. This covers bytes 0x40 to 0xFF of a timer/watchdog slot and every slot past the last one in use.
- R7: `tgt_sel` has exactly one bit set whenever `dec_err` is 0, and no bit set whenever it is 1.
- R8: A level input `i` that was low on the previous clock edge and is high on this one sets `pend_strb[i]` for exactly the following cycle.
- R9: An input held high gives no further strobe. It must be seen low on at least one edge before it can strobe again.
- R10: While `pend_strb[i]` is 1, field `i` of `pend_cpu` (bits i*CPU_W upward) holds i>>1, and field `i` of `pend_id` (bits i*5 upward) holds 29 for even i and 30 for odd i. While `pend_strb[i]` is 0, both fields are 0.
- R11: Inputs that rise on the same edge all strobe in the same cycle.
- R12: While reset is held, all strobes are 0 and every stored level is 0. An input that is already high when reset is released therefore strobes once, on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Byte offset into the private region |
| tgt_sel | output | 5 | One-hot target: bit0 snoop control, bit1 CPU interface, bit2 timer, bit3 watchdog, bit4 distributor |
| tgt_idx | output | IDX_W | Slot index (0 = current-CPU alias) |
| tgt_off | output | 12 | Offset local to the selected target |
| dec_err | output | 1 | No target claims the offset |
| lvl_in | input | 2*NUM_CPU | Timer (even) and watchdog (odd) level outputs |
| pend_strb | output | 2*NUM_CPU | One-cycle pending strobe per input |
| pend_cpu | output | 2*NUM_CPU*CPU_W | Per-strobe target CPU field |
| pend_id | output | 2*NUM_CPU*5 | Per-strobe private interrupt number field |

## Verification
The bench builds the block with NUM_CPU = 4, the largest value that fits the map. At that value the last CPU-interface slot (0x500) ends right where the first timer slot (0x600) begins, and the unused gap from 0xB00 to 0xFFF is the smallest the map allows. Both of those edges are probed. The 8 level inputs and 2-bit CPU fields let the bench use CPU indices up to 3, covering both the timer and the watchdog interrupt numbers. A single edge raises three inputs on different CPUs at once.

// File: rtl/privreg_pkg.sv
package privreg_pkg;
    localparam int ADDR_W  = 13;
    localparam int OFF_W   = 12;
    localparam int NUM_TGT = 5;
    localparam int ID_W    = 5;

    localparam int TGT_SCU  = 0;
    localparam int TGT_CPUIF = 1;
    localparam int TGT_TMR  = 2;
    localparam int TGT_WDOG = 3;
    localparam int TGT_DIST = 4;

    localparam logic [ID_W-1:0] IRQ_ID_TMR  = 5'd29;
    localparam logic [ID_W-1:0] IRQ_ID_WDOG = 5'd30;

    localparam logic [3:0] IF_FIRST_SLOT  = 4'd1;
    localparam logic [3:0] TMR_FIRST_SLOT = 4'd6;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_e;
endpackage

// File: rtl/privreg_addr_map.sv
module privreg_addr_map
    import privreg_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TGT-1:0] sel,
    output logic [IDX_W-1:0]   idx,
    output logic [OFF_W-1:0]   off,
    output logic               err
);
    localparam logic [3:0] IF_LAST_SLOT  = 4'(NUM_CPU + 1);
    localparam logic [3:0] TMR_LAST_SLOT = 4'(6 + NUM_CPU);

    logic [3:0] slot;
    logic [7:0] lo;

    assign slot = addr[11:8];
    assign lo   = addr[7:0];

    always_comb begin
        sel = '0;
        idx = '0;
        off = '0;
        err = 1'b0;
        if (addr[12]) begin
            sel[TGT_DIST] = 1'b1;
            off           = addr[11:0];
        end else if (slot == 4'd0) begin
            sel[TGT_SCU] = 1'b1;
            off          = OFF_W'(lo);
        end else if (slot <= IF_LAST_SLOT) begin
            sel[TGT_CPUIF] = 1'b1;
            idx            = IDX_W'(slot - IF_FIRST_SLOT);
            off            = OFF_W'(lo);
        end else if (slot >= TMR_FIRST_SLOT && slot <= TMR_LAST_SLOT) begin
            if (lo[7:5] == 3'd0) begin
                sel[TGT_TMR] = 1'b1;
                idx          = IDX_W'(slot - TMR_FIRST_SLOT);
                off          = OFF_W'(lo[4:0]);
            end else if (lo[7:5] == 3'd1) begin
                sel[TGT_WDOG] = 1'b1;
                idx           = IDX_W'(slot - TMR_FIRST_SLOT);
                off           = OFF_W'(lo[4:0]);
            end else begin
                err = 1'b1;
            end
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/privreg_edge_cell.sv
module privreg_edge_cell
    import privreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic strb
);
    edge_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            EDGE_LOW:  if (lvl)  st_nx = EDGE_HIGH;   // FIRE
            EDGE_HIGH: if (!lvl) st_nx = EDGE_LOW;    // ARM
            default:             st_nx = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EDGE_LOW;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb <= 1'b0;
        else        strb <= (st == EDGE_LOW) && lvl;
    end

    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> $past(lvl));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> !strb);
endmodule

// File: rtl/privreg_router.sv
module privreg_router
    import privreg_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int NLVL  = 2 * NUM_CPU,
    localparam int IDX_W = $clog2(NUM_CPU + 1),
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    output logic [NUM_TGT-1:0]      tgt_sel,
    output logic [IDX_W-1:0]        tgt_idx,
    output logic [OFF_W-1:0]        tgt_off,
    output logic                    dec_err,
    input  logic [NLVL-1:0]         lvl_in,
    output logic [NLVL-1:0]         pend_strb,
    output logic [NLVL*CPU_W-1:0]   pend_cpu,
    output logic [NLVL*ID_W-1:0]    pend_id
);
    privreg_addr_map #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_map (
        .addr(bus_addr),
        .sel (tgt_sel),
        .idx (tgt_idx),
        .off (tgt_off),
        .err (dec_err)
    );

    for (genvar i = 0; i < NLVL; i++) begin : g_cell
        localparam logic [CPU_W-1:0] CPU_OF = CPU_W'(i / 2);
        localparam logic [ID_W-1:0]  ID_OF  = (i % 2 == 1) ? IRQ_ID_WDOG : IRQ_ID_TMR;

        privreg_edge_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_in[i]),
            .strb (pend_strb[i])
        );

        assign pend_cpu[i*CPU_W +: CPU_W] = pend_strb[i] ? CPU_OF : '0;
        assign pend_id[i*ID_W +: ID_W]    = pend_strb[i] ? ID_OF  : '0;
    end

    assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_err |-> $onehot(tgt_sel));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (tgt_sel == '0 && tgt_off == '0 && tgt_idx == '0));

    assert_dist_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[TGT_DIST] |-> bus_addr[12]);

    assert_tmr_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[TGT_TMR] || tgt_sel[TGT_WDOG]) |-> (int'(tgt_idx) <= NUM_CPU));
endmodule

// File: tb/privreg_router_test.sv
module privreg_router_test;
    localparam int NCPU  = 4;
    localparam int NLVL  = 2 * NCPU;
    localparam int IDX_W = 3;
    localparam int CPU_W = 2;

    typedef struct packed {
        logic [12:0] addr;
        logic [4:0]  sel;
        logic [2:0]  idx;
        logic [11:0] off;
        logic        err;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{13'h0000, 5'b00001, 3'd0, 12'h000, 1'b0},
        '{13'h00FF, 5'b00001, 3'd0, 12'h0FF, 1'b0},
        '{13'h0100, 5'b00010, 3'd0, 12'h000, 1'b0},
        '{13'h01A4, 5'b00010, 3'd0, 12'h0A4, 1'b0},
        '{13'h0534, 5'b00010, 3'd4, 12'h034, 1'b0},
        '{13'h0600, 5'b00100, 3'd0, 12'h000, 1'b0},
        '{13'h061F, 5'b00100, 3'd0, 12'h01F, 1'b0},
        '{13'h0620, 5'b01000, 3'd0, 12'h000, 1'b0},
        '{13'h093F, 5'b01000, 3'd3, 12'h01F, 1'b0},
        '{13'h0A05, 5'b00100, 3'd4, 12'h005, 1'b0},
        '{13'h0640, 5'b00000, 3'd0, 12'h000, 1'b1},
        '{13'h06FF, 5'b00000, 3'd0, 12'h000, 1'b1},
        '{13'h0B00, 5'b00000, 3'd0, 12'h000, 1'b1},
        '{13'h0FFC, 5'b00000, 3'd0, 12'h000, 1'b1},
        '{13'h1000, 5'b10000, 3'd0, 12'h000, 1'b0},
        '{13'h1FFF, 5'b10000, 3'd0, 12'hFFF, 1'b0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [12:0]           bus_addr = '0;
    logic [4:0]            tgt_sel;
    logic [IDX_W-1:0]      tgt_idx;
    logic [11:0]           tgt_off;
    logic                  dec_err;
    logic [NLVL-1:0]       lvl_in = '0;
    logic [NLVL-1:0]       pend_strb;
    logic [NLVL*CPU_W-1:0] pend_cpu;
    logic [NLVL*5-1:0]     pend_id;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    privreg_router #(.NUM_CPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .tgt_sel(tgt_sel), .tgt_idx(tgt_idx), .tgt_off(tgt_off), .dec_err(dec_err),
        .lvl_in(lvl_in), .pend_strb(pend_strb), .pend_cpu(pend_cpu), .pend_id(pend_id)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [4:0] sel);
        case (sel)
            5'b00001: return "R1";
            5'b00010: return "R2";
            5'b00100: return "R3";
            5'b01000: return "R4";
            5'b10000: return "R5";
            default:  return "R6";
        endcase
    endfunction

    task automatic check_fields(input int i, input logic [1:0] cpu, input logic [4:0] id);
        check("R10", $sformatf("cpu field %0d", i), 64'(pend_cpu[i*CPU_W +: CPU_W]), 64'(cpu));
        check("R10", $sformatf("id field %0d", i),  64'(pend_id[i*5 +: 5]), 64'(id));
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R12: input 0 high throughout reset
        lvl_in = 8'b0000_0001;
        step();
        step();
        check("R12", "strobes in reset", 64'(pend_strb), 64'h0);
        rst_n = 1'b1;
        step();
        check("R12", "strobe after release", 64'(pend_strb), 64'h01);
        check_fields(0, 2'd0, 5'd29);
        step();
        check("R9", "held high", 64'(pend_strb), 64'h0);
        step();
        check("R9", "still held high", 64'(pend_strb), 64'h0);

        // Address vector table: R1..R7
        for (int v = 0; v < NVEC; v++) begin
            bus_addr = VEC[v].addr;
            #1;
            check(req_of(VEC[v].sel), $sformatf("sel @%0h", VEC[v].addr), 64'(tgt_sel), 64'(VEC[v].sel));
            check(req_of(VEC[v].sel), $sformatf("idx @%0h", VEC[v].addr), 64'(tgt_idx), 64'(VEC[v].idx));
            check(req_of(VEC[v].sel), $sformatf("off @%0h", VEC[v].addr), 64'(tgt_off), 64'(VEC[v].off));
            check("R7", $sformatf("err @%0h", VEC[v].addr), 64'(dec_err), 64'(VEC[v].err));
        end
        @(negedge clk);

        // R8/R10: watchdog of CPU 1 (input 3)
        lvl_in = 8'b0000_0000;
        step();
        check("R8", "low gives nothing", 64'(pend_strb), 64'h0);
        lvl_in = 8'b0000_1000;
        step();
        check("R8", "rise on input 3", 64'(pend_strb), 64'h08);
        check_fields(3, 2'd1, 5'd30);
        check_fields(2, 2'd0, 5'd0);
        step();
        check("R8", "one cycle only", 64'(pend_strb), 64'h0);
        check_fields(3, 2'd0, 5'd0);

        // R11: simultaneous rises on 7, 4, 0 while 3 stays high
        lvl_in = 8'b1001_1001;
        step();
        check("R11", "parallel strobes", 64'(pend_strb), 64'h91);
        check_fields(7, 2'd3, 5'd30);
        check_fields(4, 2'd2, 5'd29);
        check_fields(0, 2'd0, 5'd29);
        step();
        check("R9", "no repeat", 64'(pend_strb), 64'h0);

        // R9: re-arm through one low cycle
        lvl_in = 8'b1001_1000;
        step();
        check("R9", "falling gives nothing", 64'(pend_strb), 64'h0);
        lvl_in = 8'b1001_1001;
        step();
        check("R9", "re-armed strobe", 64'(pend_strb), 64'h01);

        // R12: reset mid-run clears strobes and stored levels
        lvl_in = 8'b0000_0010;
        rst_n = 1'b0;
        step();
        check("R12", "reset clears", 64'(pend_strb), 64'h0);
        rst_n = 1'b1;
        step();
        check("R12", "level high at release", 64'(pend_strb), 64'h02);
        check_fields(1, 2'd0, 5'd30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule